// File: doc/BRIEF.md
# Integer Execute Stage for a 32-bit Load/Store Core

This block is the purely combinational execute stage of a simple 32-bit load/store RISC pipeline. It receives the two register operands that were read for an instruction, plus the raw instruction fields it needs: the 6-bit major opcode, the 6-bit function code, the 5-bit shift amount and the 16-bit immediate. It decodes these fields itself and returns a 32-bit result in the same cycle.

Register-format words carry a major opcode of zero, and the function code selects the operation. Immediate-format words are selected by the major opcode alone. The block also reports whether the two register operands are equal, so that the branch logic can resolve its two compare-for-equality branches without a second comparator.

Any encoding the stage does not implement gives a zero result and raises an indicator. All additions and subtractions wrap modulo 2^32, and no overflow is ever reported.

Top module: `rx_exec_unit`

## Requirements
- R1: With opcode 0 and funct 32, result = rs_val + rt_val, wrapping modulo 2^32. With opcode 8, result = rs_val plus the immediate sign-extended from bit 15, also wrapping.
- R2: With opcode 0 and funct 34, result = rs_val - rt_val, wrapping modulo 2^32.
- R3: With opcode 0, funct 36 gives rs_val AND rt_val, funct 37 gives rs_val OR rt_val, and funct 39 gives NOT(rs_val OR rt_val). A funct 39 operation with rt_val = 0 therefore gives the bitwise inverse of rs_val.
- R4: Opcode 12 gives rs_val AND the zero-extended immediate. Opcode 13 gives rs_val OR the zero-extended immediate.
- R5: With opcode 0, funct 0 shifts rt_val left by shamt and funct 2 shifts rt_val right by shamt. Both fill the vacated bits with zeros, and rs_val plays no part.
- R6: With opcode 0, funct 42 gives 1 when rs_val < rt_val as two's-complement numbers, and 0 otherwise. Funct 43 gives the same answer for an unsigned compare. Result bits [31:1] are always zero for both.
- R7: Opcode 10 compares rs_val against the sign-extended immediate as signed numbers. Opcode 11 compares rs_val against the sign-extended immediate as unsigned numbers. In both cases the result is 1 when rs_val is less, and 0 otherwise.
- R8: Opcode 15 gives the immediate in bits [31:16] and zeros in bits [15:0].
- R9: `equal` is 1 exactly when rs_val equals rt_val, whatever the opcode and funct.
- R10: Any opcode other than 0, 8, 10, 11, 12, 13 or 15 raises `illegal`. So does opcode 0 with a funct other than 0, 2, 32, 34, 36, 37, 39, 42 or 43. In either case the result is 0. Every supported encoding leaves `illegal` at 0.
- R11: Fields an operation does not use have no effect on its result. The immediate does not affect register-format operations, and shamt does not affect non-shift operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand, and the value that is shifted |
| imm16 | input | 16 | Immediate field of the instruction |
| shamt | input | 5 | Shift amount field |
| opcode | input | 6 | Major opcode field |
| funct | input | 6 | Function code field, used when opcode is 0 |
| result | output | 32 | Execute result |
| equal | output | 1 | rs_val equals rt_val |
| illegal | output | 1 | Encoding not supported by this stage |

## Verification
The hardest cases to reach are the ones where the signed and unsigned answers differ. This happens when the operands straddle the sign boundary, and also for the unsigned immediate compare, where a sign-extended negative constant becomes a very large unsigned bound. The vector table therefore pairs operands such as all-ones against one, and an immediate of 0xFFFF against small and all-ones register values, so that each compare flavour is forced to give the opposite answer from its sibling. The shifter is then swept across every shift amount in both directions, and a separate sweep applies subtract to equal operands, so that the equality flag and the zero difference are observed together.

// File: rtl/rx_exec_pkg.sv
// Shared encodings and selector types for the integer execute stage.
// Assumes 6-bit opcode and function-code fields.
package rx_exec_pkg;

    localparam int CODE_W = 6;

    // Major opcodes
    localparam logic [CODE_W-1:0] OPC_REG   = 6'd0;
    localparam logic [CODE_W-1:0] OPC_ADDI  = 6'd8;
    localparam logic [CODE_W-1:0] OPC_SLTI  = 6'd10;
    localparam logic [CODE_W-1:0] OPC_SLTIU = 6'd11;
    localparam logic [CODE_W-1:0] OPC_ANDI  = 6'd12;
    localparam logic [CODE_W-1:0] OPC_ORI   = 6'd13;
    localparam logic [CODE_W-1:0] OPC_LUI   = 6'd15;

    // Function codes used with OPC_REG
    localparam logic [CODE_W-1:0] FN_SLL  = 6'd0;
    localparam logic [CODE_W-1:0] FN_SRL  = 6'd2;
    localparam logic [CODE_W-1:0] FN_ADD  = 6'd32;
    localparam logic [CODE_W-1:0] FN_SUB  = 6'd34;
    localparam logic [CODE_W-1:0] FN_AND  = 6'd36;
    localparam logic [CODE_W-1:0] FN_OR   = 6'd37;
    localparam logic [CODE_W-1:0] FN_NOR  = 6'd39;
    localparam logic [CODE_W-1:0] FN_SLT  = 6'd42;
    localparam logic [CODE_W-1:0] FN_SLTU = 6'd43;

    // Internal operation selector
    typedef enum logic [3:0] {
        SEL_ADD, SEL_SUB, SEL_AND, SEL_OR, SEL_NOR,
        SEL_SLL, SEL_SRL, SEL_SLT, SEL_SLTU, SEL_LUI, SEL_NONE
    } alu_sel_e;

    // Source of the second operand
    typedef enum logic [1:0] {
        SRC_REG, SRC_SEXT, SRC_ZEXT
    } bsrc_e;

endpackage

// File: rtl/rx_exec_decode.sv
// Field decoder: turns opcode/funct into an operation selector, the
// second-operand source and an unsupported-encoding flag.
// Assumes opcode 0 marks a register-format word.
module rx_exec_decode
    import rx_exec_pkg::*;
(
    input  logic [CODE_W-1:0] opcode,
    input  logic [CODE_W-1:0] funct,
    output alu_sel_e          sel,
    output bsrc_e             bsrc,
    output logic              bad_code
);

    // Decode the operation from the raw fields
    always_comb begin
        sel      = SEL_NONE;
        bsrc     = SRC_REG;
        bad_code = 1'b0;
        if (opcode == OPC_REG) begin
            case (funct)
                FN_SLL:  sel = SEL_SLL;
                FN_SRL:  sel = SEL_SRL;
                FN_ADD:  sel = SEL_ADD;
                FN_SUB:  sel = SEL_SUB;
                FN_AND:  sel = SEL_AND;
                FN_OR:   sel = SEL_OR;
                FN_NOR:  sel = SEL_NOR;
                FN_SLT:  sel = SEL_SLT;
                FN_SLTU: sel = SEL_SLTU;
                default: bad_code = 1'b1;
            endcase
        end else begin
            case (opcode)
                OPC_ADDI:  begin sel = SEL_ADD;  bsrc = SRC_SEXT; end
                OPC_SLTI:  begin sel = SEL_SLT;  bsrc = SRC_SEXT; end
                OPC_SLTIU: begin sel = SEL_SLTU; bsrc = SRC_SEXT; end
                OPC_ANDI:  begin sel = SEL_AND;  bsrc = SRC_ZEXT; end
                OPC_ORI:   begin sel = SEL_OR;   bsrc = SRC_ZEXT; end
                OPC_LUI:   begin sel = SEL_LUI;  bsrc = SRC_ZEXT; end
                default:   bad_code = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/rx_exec_shift.sv
// Logarithmic barrel shifter with zero fill; direction chosen at run time.
// Assumes SH_W stages cover every shift amount below XLEN.
module rx_exec_shift #(
    parameter int XLEN = 32,
    parameter int SH_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] din,
    input  logic [SH_W-1:0] amt,
    input  logic            to_left,
    output logic [XLEN-1:0] dout
);

    logic [XLEN-1:0] stg [SH_W+1];

    assign stg[0] = din;

    // One stage per shift-amount bit, each moving by a power of two
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stg[k+1] = !amt[k] ? stg[k]
                        : (to_left ? (stg[k] << STEP) : (stg[k] >> STEP));
    end

    assign dout = stg[SH_W];

    // Zero shift amount must pass the operand through unchanged
    always_comb begin
        // R5
        if (amt == '0) begin
            zero_amt_pass_chk: assert (dout == din);
        end
    end

endmodule

// File: rtl/rx_exec_compare.sv
// Operand comparator: signed and unsigned less-than on the selected pair,
// plus equality of the two register operands.
module rx_exec_compare #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    input  logic [XLEN-1:0] rt_val,
    output logic            lt_signed,
    output logic            lt_unsigned,
    output logic            same
);

    // Two compare flavours on the same operand pair
    always_comb begin
        lt_signed   = $signed(lhs) < $signed(rhs);
        lt_unsigned = lhs < rhs;
    end

    // Register-operand equality for branch resolution
    assign same = (lhs == rt_val);

    // Signed and unsigned answers agree when the sign bits agree
    always_comb begin
        // R6
        if (lhs[XLEN-1] == rhs[XLEN-1]) begin
            lt_agree_chk: assert (lt_signed == lt_unsigned);
        end
    end

endmodule

// File: rtl/rx_exec_unit.sv
// Top of the integer execute stage. Decodes raw fields, forms the second
// operand, and selects among adder, logic, shifter, compare and
// upper-immediate results. Purely combinational; addition wraps.
module rx_exec_unit
    import rx_exec_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    localparam int SH_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]   rs_val,
    input  logic [XLEN-1:0]   rt_val,
    input  logic [IMM_W-1:0]  imm16,
    input  logic [SH_W-1:0]   shamt,
    input  logic [CODE_W-1:0] opcode,
    input  logic [CODE_W-1:0] funct,
    output logic [XLEN-1:0]   result,
    output logic              equal,
    output logic              illegal
);

    localparam int UP_SH = XLEN - IMM_W;

    alu_sel_e        sel;
    bsrc_e           bsrc;
    logic [XLEN-1:0] b_eff;
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] sh_out;
    logic            lt_s;
    logic            lt_u;

    rx_exec_decode u_dec (
        .opcode   (opcode),
        .funct    (funct),
        .sel      (sel),
        .bsrc     (bsrc),
        .bad_code (illegal)
    );

    // Form the second operand from register or immediate
    always_comb begin
        case (bsrc)
            SRC_SEXT: b_eff = {{UP_SH{imm16[IMM_W-1]}}, imm16};
            SRC_ZEXT: b_eff = {{UP_SH{1'b0}}, imm16};
            default:  b_eff = rt_val;
        endcase
    end

    // Shared adder; subtract by inverting b and injecting a carry
    always_comb begin
        if (sel == SEL_SUB) sum = rs_val + ~b_eff + {{(XLEN-1){1'b0}}, 1'b1};
        else                sum = rs_val + b_eff;
    end

    rx_exec_shift #(.XLEN(XLEN), .SH_W(SH_W)) u_shift (
        .din     (rt_val),
        .amt     (shamt),
        .to_left (sel == SEL_SLL),
        .dout    (sh_out)
    );

    rx_exec_compare #(.XLEN(XLEN)) u_cmp (
        .lhs         (rs_val),
        .rhs         (b_eff),
        .rt_val      (rt_val),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u),
        .same        (equal)
    );

    // Result select
    always_comb begin
        case (sel)
            SEL_ADD, SEL_SUB: result = sum;
            SEL_AND:          result = rs_val & b_eff;
            SEL_OR:           result = rs_val | b_eff;
            SEL_NOR:          result = ~(rs_val | b_eff);
            SEL_SLL, SEL_SRL: result = sh_out;
            SEL_SLT:          result = {{(XLEN-1){1'b0}}, lt_s};
            SEL_SLTU:         result = {{(XLEN-1){1'b0}}, lt_u};
            SEL_LUI:          result = b_eff << UP_SH;
            default:          result = '0;
        endcase
    end

    // Cross-checks between decoder, adder, comparator and result select
    always_comb begin
        // R10
        if (illegal) begin
            illegal_zero_chk: assert (result == '0);
        end
        // R8
        if (!illegal && opcode == OPC_LUI) begin
            lui_low_clear_chk: assert (result[UP_SH-1:0] == '0);
        end
        // R6
        if (!illegal && (sel == SEL_SLT || sel == SEL_SLTU)) begin
            slt_bool_chk: assert (result[XLEN-1:1] == '0);
        end
        // R9
        if (equal && opcode == OPC_REG && funct == FN_SUB) begin
            equal_sub_zero_chk: assert (result == '0);
        end
    end

endmodule

// File: tb/sim_rx_exec_unit.sv
module sim_rx_exec_unit;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] rs_val, rt_val, result;
    logic [15:0] imm16;
    logic [4:0]  shamt;
    logic [5:0]  opcode, funct;
    logic        equal, illegal;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    rx_exec_unit u0 (
        .rs_val(rs_val), .rt_val(rt_val), .imm16(imm16), .shamt(shamt),
        .opcode(opcode), .funct(funct),
        .result(result), .equal(equal), .illegal(illegal)
    );

    typedef struct packed {
        logic [5:0]  opc;
        logic [5:0]  fn;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic [4:0]  sh;
        logic [31:0] exp;
        logic        ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VT [NV] = '{
        // R1 / R11: add, imm and shamt are noise
        '{6'd0, 6'd32, 32'h5, 32'h7, 16'hFFFF, 5'd31, 32'hC, 1'b0, 4'd1},
        '{6'd0, 6'd32, 32'hFFFFFFFF, 32'h2, 16'h0, 5'd0, 32'h1, 1'b0, 4'd1},
        '{6'd8, 6'd0, 32'hA, 32'h0, 16'hFFFF, 5'd0, 32'h9, 1'b0, 4'd1},
        '{6'd8, 6'd0, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0, 32'h80000000, 1'b0, 4'd1},
        '{6'd0, 6'd32, 32'h0000ABCD, 32'h0000ABCD, 16'h0, 5'd0, 32'h0001579A, 1'b0, 4'd1},
        // R2: subtract
        '{6'd0, 6'd34, 32'h3, 32'h5, 16'h0, 5'd0, 32'hFFFFFFFE, 1'b0, 4'd2},
        '{6'd0, 6'd34, 32'h80000000, 32'h1, 16'h0, 5'd0, 32'h7FFFFFFF, 1'b0, 4'd2},
        // R3: logic
        '{6'd0, 6'd36, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0, 5'd0, 32'hF000F000, 1'b0, 4'd3},
        '{6'd0, 6'd37, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0, 5'd0, 32'hFFF0FFF0, 1'b0, 4'd3},
        '{6'd0, 6'd39, 32'h12345678, 32'h0, 16'h0, 5'd0, 32'hEDCBA987, 1'b0, 4'd3},
        '{6'd0, 6'd39, 32'hF0F0F0F0, 32'h0F0F0000, 16'h0, 5'd0, 32'h00000F0F, 1'b0, 4'd3},
        // R4: zero-extended logic immediates
        '{6'd12, 6'd0, 32'hFFFFFFFF, 32'h0, 16'h8001, 5'd0, 32'h00008001, 1'b0, 4'd4},
        '{6'd13, 6'd0, 32'h12340000, 32'h0, 16'hF00F, 5'd0, 32'h1234F00F, 1'b0, 4'd4},
        // R5: shifts
        '{6'd0, 6'd0, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd31, 32'h80000000, 1'b0, 4'd5},
        '{6'd0, 6'd0, 32'h0, 32'hF000000F, 16'h0, 5'd4, 32'h000000F0, 1'b0, 4'd5},
        '{6'd0, 6'd2, 32'hFFFFFFFF, 32'h80000000, 16'h0, 5'd31, 32'h1, 1'b0, 4'd5},
        '{6'd0, 6'd2, 32'h0, 32'hF0000000, 16'h0, 5'd4, 32'h0F000000, 1'b0, 4'd5},
        '{6'd0, 6'd0, 32'h0, 32'hDEADBEEF, 16'h0, 5'd0, 32'hDEADBEEF, 1'b0, 4'd5},
        // R6: register compares
        '{6'd0, 6'd42, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 32'h1, 1'b0, 4'd6},
        '{6'd0, 6'd43, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 32'h0, 1'b0, 4'd6},
        '{6'd0, 6'd42, 32'h1, 32'hFFFFFFFF, 16'h0, 5'd0, 32'h0, 1'b0, 4'd6},
        '{6'd0, 6'd43, 32'h1, 32'hFFFFFFFF, 16'h0, 5'd0, 32'h1, 1'b0, 4'd6},
        '{6'd0, 6'd42, 32'h5, 32'h5, 16'h0, 5'd0, 32'h0, 1'b0, 4'd6},
        // R7: immediate compares
        '{6'd10, 6'd0, 32'hFFFFFFFE, 32'h0, 16'hFFFF, 5'd0, 32'h1, 1'b0, 4'd7},
        '{6'd10, 6'd0, 32'h0, 32'h0, 16'h8000, 5'd0, 32'h0, 1'b0, 4'd7},
        '{6'd11, 6'd0, 32'h5, 32'h0, 16'hFFFF, 5'd0, 32'h1, 1'b0, 4'd7},
        '{6'd11, 6'd0, 32'hFFFFFFFF, 32'h0, 16'hFFFF, 5'd0, 32'h0, 1'b0, 4'd7},
        '{6'd11, 6'd0, 32'h0, 32'h0, 16'h0001, 5'd0, 32'h1, 1'b0, 4'd7},
        // R8: upper immediate
        '{6'd15, 6'd0, 32'hFFFFFFFF, 32'h0, 16'h007D, 5'd0, 32'h007D0000, 1'b0, 4'd8},
        '{6'd15, 6'd0, 32'h0, 32'h0, 16'hFFFF, 5'd0, 32'hFFFF0000, 1'b0, 4'd8},
        // R10: unsupported encodings
        '{6'd0, 6'd33, 32'h5, 32'h7, 16'h0, 5'd0, 32'h0, 1'b1, 4'd10},
        '{6'd35, 6'd0, 32'h5, 32'h7, 16'h1, 5'd0, 32'h0, 1'b1, 4'd10},
        '{6'd0, 6'd63, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0, 5'd0, 32'h0, 1'b1, 4'd10}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [5:0] opc, input logic [5:0] fn,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, input logic [4:0] sh);
        @(posedge clk);
        opcode = opc; funct = fn; rs_val = a; rt_val = b; imm16 = imm; shamt = sh;
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // Quiescent state: all-zero word is a legal zero shift of zero (R5, R9, R10)
        apply(6'd0, 6'd0, 32'h0, 32'h0, 16'h0, 5'd0);
        check("R10 idle result", result, 32'h0);
        check("R10 idle illegal", {31'b0, illegal}, 32'h0);
        check("R9 idle equal", {31'b0, equal}, 32'h1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            apply(VT[i].opc, VT[i].fn, VT[i].a, VT[i].b, VT[i].imm, VT[i].sh);
            check($sformatf("R%0d vec%0d result", VT[i].req, i), result, VT[i].exp);
            check($sformatf("R10 vec%0d illegal", i), {31'b0, illegal}, {31'b0, VT[i].ill});
            check($sformatf("R9 vec%0d equal", i), {31'b0, equal}, {31'b0, VT[i].a == VT[i].b});
        end

        // R5: every shift amount, both directions, with rs_val as noise
        for (int s = 0; s < 32; s++) begin
            apply(6'd0, 6'd0, 32'hFFFFFFFF, 32'hA5C3_0F69, 16'hFFFF, 5'(s));
            check($sformatf("R5 sll by %0d", s), result, 32'hA5C3_0F69 << s);
            apply(6'd0, 6'd2, 32'hFFFFFFFF, 32'hA5C3_0F69, 16'hFFFF, 5'(s));
            check($sformatf("R5 srl by %0d", s), result, 32'hA5C3_0F69 >> s);
        end

        // R3: nor against zero is NOT
        for (int k = 0; k < 8; k++) begin
            logic [31:0] v;
            v = 32'h1357_9BDF * (k + 1);
            apply(6'd0, 6'd39, v, 32'h0, 16'h0, 5'd0);
            check("R3 nor as not", result, ~v);
        end

        // R9 / R2: equal operands give zero difference and raise equal
        for (int k = 0; k < 6; k++) begin
            logic [31:0] v;
            v = 32'h8000_0001 ^ (32'h0F0F_0F0F << k);
            apply(6'd0, 6'd34, v, v, 16'h0, 5'd0);
            check("R2 sub of equal", result, 32'h0);
            check("R9 equal on same", {31'b0, equal}, 32'h1);
            apply(6'd0, 6'd34, v, v ^ 32'h1, 16'h0, 5'd0);
            check("R9 equal on differ", {31'b0, equal}, 32'h0);
        end

        // R11: immediate and shamt leave a register-format AND untouched
        apply(6'd0, 6'd36, 32'hCAFE_F00D, 32'h0FF0_FFFF, 16'h0000, 5'd0);
        check("R11 and base", result, 32'h0AF0_F00D);
        apply(6'd0, 6'd36, 32'hCAFE_F00D, 32'h0FF0_FFFF, 16'hFFFF, 5'd17);
        check("R11 and with noise", result, 32'h0AF0_F00D);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule